// File: doc/BRIEF.md
# Timed Bus-Lock Controller

This block sits beside a processor pipeline and controls a short atomic window. A lock instruction strobe starts the window. For as long as the window is open the block holds the shared bus locked against other masters and masks interrupts, so a brief read-modify-write sequence completes without interference. The bus arbiter and the interrupt controller lie outside this block. They only watch its two hold outputs.

The window closes by itself, so a faulty sequence cannot hold the bus forever. Three events close it: a completed memory write, a raised exception, or expiry of a fixed countdown of `WINDOW` cycles (32 by default). A sticky flag records whether the most recent close was a timeout. The next lock entry clears that flag. A lock instruction issued while the window is already open restarts the countdown from its full length.

All outputs are registered. An event sampled at a rising clock edge is visible on the outputs right after that edge. When several events arrive in the same cycle, they are resolved in this order: exception, then lock instruction, then write completion, then expiry.

Top module: `bus_lock_window`

## Requirements
- R1: While `rst` is high at a clock edge, and after it, `bus_lock`, `irq_mask` and `lock_timed_out` are all 0 until a lock instruction is taken.
- R2: When `lock_op` is 1 and `exc_raise` is 0 at an edge, `bus_lock` and `irq_mask` are 1 and `lock_timed_out` is 0 after that edge.
- R3: `irq_mask` equals `bus_lock` in every cycle.
- R4: After an entry with no further event, the lock stays held for exactly `WINDOW` cycles. At the `WINDOW`-th edge after entry, `bus_lock` and `irq_mask` drop and `lock_timed_out` becomes 1.
- R5: When `exc_raise` is 1 at an edge, `bus_lock` is 0 after that edge, even if `lock_op` is also 1. An exception never sets `lock_timed_out`.
- R6: When `mem_wr_done` is 1 at an edge while locked, and `lock_op` and `exc_raise` are both 0, the lock is released after that edge and `lock_timed_out` stays 0.
- R7: A `lock_op` taken while locked restarts the countdown. The lock then stays held for `WINDOW` cycles counted from that edge.
- R8: `lock_timed_out` holds its value while unlocked, whatever `mem_wr_done` and `exc_raise` do. Only the next lock entry clears it.
- R9: While unlocked, `mem_wr_done` and `exc_raise` leave `bus_lock` at 0.
- R10: A `lock_op` in the same cycle as a write completion, or as the final countdown cycle, keeps the lock held and restarts the countdown. It does not release the lock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| lock_op | input | 1 | One-cycle strobe: lock instruction executed |
| mem_wr_done | input | 1 | One-cycle strobe: a memory write completed |
| exc_raise | input | 1 | An exception is raised this cycle |
| bus_lock | output | 1 | Shared bus held locked |
| irq_mask | output | 1 | Interrupts masked |
| lock_timed_out | output | 1 | Sticky: last window ended by countdown expiry |

## Verification
The hardest situations to reach from the ports are expiry and a restart that lands on the final countdown cycle. Random write and exception traffic almost always closes the window long before 32 quiet cycles have passed. Directed sequences therefore open the window, hold every input low for exactly `WINDOW` cycles, and place a lock instruction on the last cycle and alongside a write. Seeded random traffic with sparse exceptions then mixes every event ordering. A bench-side model, written from the priority order above, supplies the expected value at each cycle.

// File: rtl/bus_lock_window_pkg.sv
package bus_lock_window_pkg;

  typedef enum logic [2:0] {
    ACT_IDLE     = 3'd0,
    ACT_ENTER    = 3'd1,
    ACT_HOLD     = 3'd2,
    ACT_EXIT_EXC = 3'd3,
    ACT_EXIT_WR  = 3'd4,
    ACT_EXIT_TMO = 3'd5
  } lock_act_t;

  function automatic logic act_is_exit(input lock_act_t a);
    return (a == ACT_EXIT_EXC) || (a == ACT_EXIT_WR) || (a == ACT_EXIT_TMO);
  endfunction

endpackage

// File: rtl/lock_action_sel.sv
module lock_action_sel
  import bus_lock_window_pkg::*;
(
  input  logic      active,
  input  logic      lock_op,
  input  logic      wr_done,
  input  logic      exc,
  input  logic      cnt_last,
  output lock_act_t act
);

  // Priority: exception, lock instruction, write completion, expiry.
  always_comb begin
    if (exc) begin
      act = active ? ACT_EXIT_EXC : ACT_IDLE;
    end else if (lock_op) begin
      act = ACT_ENTER;
    end else if (!active) begin
      act = ACT_IDLE;
    end else if (wr_done) begin
      act = ACT_EXIT_WR;
    end else if (cnt_last) begin
      act = ACT_EXIT_TMO;
    end else begin
      act = ACT_HOLD;
    end
  end

endmodule

// File: rtl/lock_countdown.sv
module lock_countdown
  import bus_lock_window_pkg::*;
#(
  parameter int WINDOW = 32
) (
  input  logic      clk,
  input  logic      rst,
  input  lock_act_t act,
  output logic      cnt_last
);

  localparam int CW = $clog2(WINDOW + 1);
  localparam logic [CW-1:0] FULL = CW'(WINDOW);
  localparam logic [CW-1:0] ONE  = CW'(1);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
    end else begin
      case (act)
        ACT_ENTER: cnt_q <= FULL;
        ACT_HOLD:  cnt_q <= cnt_q - ONE;
        default:   cnt_q <= '0;
      endcase
    end
  end

  assign cnt_last = (cnt_q == ONE);

  assert_cnt_bound_R4: assert property (@(posedge clk) disable iff (rst)
    cnt_q <= FULL);

  assert_hold_nonzero_R4: assert property (@(posedge clk) disable iff (rst)
    (act == ACT_HOLD) |-> (cnt_q > ONE));

endmodule

// File: rtl/lock_state_regs.sv
module lock_state_regs
  import bus_lock_window_pkg::*;
(
  input  logic      clk,
  input  logic      rst,
  input  lock_act_t act,
  output logic      active,
  output logic      mask_q,
  output logic      tmo_q
);

  logic active_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      active_q <= 1'b0;
      mask_q   <= 1'b0;
    end else if (act == ACT_ENTER) begin
      active_q <= 1'b1;
      mask_q   <= 1'b1;
    end else if (act_is_exit(act)) begin
      active_q <= 1'b0;
      mask_q   <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      tmo_q <= 1'b0;
    end else if (act == ACT_ENTER) begin
      tmo_q <= 1'b0;
    end else if (act == ACT_EXIT_TMO) begin
      tmo_q <= 1'b1;
    end
  end

  assign active = active_q;

  assert_mask_tracks_R3: assert property (@(posedge clk) disable iff (rst)
    mask_q == active_q);

  assert_tmo_only_on_expiry_R4: assert property (@(posedge clk) disable iff (rst)
    $rose(tmo_q) |-> (!active_q && $past(active_q)));

  assert_tmo_idle_only_R8: assert property (@(posedge clk) disable iff (rst)
    tmo_q |-> !active_q);

endmodule

// File: rtl/bus_lock_window.sv
module bus_lock_window
  import bus_lock_window_pkg::*;
#(
  parameter int WINDOW = 32
) (
  input  logic clk,
  input  logic rst,
  input  logic lock_op,
  input  logic mem_wr_done,
  input  logic exc_raise,
  output logic bus_lock,
  output logic irq_mask,
  output logic lock_timed_out
);

  localparam int RW = $clog2(WINDOW + 2);

  lock_act_t act;
  logic      active;
  logic      cnt_last;

  lock_action_sel u_sel (
    .active   (active),
    .lock_op  (lock_op),
    .wr_done  (mem_wr_done),
    .exc      (exc_raise),
    .cnt_last (cnt_last),
    .act      (act)
  );

  lock_countdown #(.WINDOW(WINDOW)) u_cnt (
    .clk      (clk),
    .rst      (rst),
    .act      (act),
    .cnt_last (cnt_last)
  );

  lock_state_regs u_state (
    .clk    (clk),
    .rst    (rst),
    .act    (act),
    .active (active),
    .mask_q (irq_mask),
    .tmo_q  (lock_timed_out)
  );

  assign bus_lock = active;

  // Held-cycle counter for the window assertion (R4, R7).
  logic [RW-1:0] held_run;
  always_ff @(posedge clk) begin
    if (rst) begin
      held_run <= '0;
    end else if (lock_op && !exc_raise) begin
      held_run <= RW'(1);
    end else if (bus_lock && held_run != '1) begin
      held_run <= held_run + RW'(1);
    end else if (!bus_lock) begin
      held_run <= '0;
    end
  end

  assert_window_limit_R4: assert property (@(posedge clk) disable iff (rst)
    bus_lock |-> (held_run <= RW'(WINDOW)));

  assert_lock_entry_R2: assert property (@(posedge clk) disable iff (rst)
    (lock_op && !exc_raise) |=> (bus_lock && irq_mask && !lock_timed_out));

  assert_exc_release_R5: assert property (@(posedge clk) disable iff (rst)
    exc_raise |=> !bus_lock);

  assert_wr_release_R6: assert property (@(posedge clk) disable iff (rst)
    (bus_lock && mem_wr_done && !lock_op && !exc_raise) |=> (!bus_lock && !lock_timed_out));

  assert_tmo_sticky_R8: assert property (@(posedge clk) disable iff (rst)
    (!bus_lock && !lock_op) |=> $stable(lock_timed_out));

  assert_idle_stays_R9: assert property (@(posedge clk) disable iff (rst)
    (!bus_lock && !lock_op) |=> !bus_lock);

endmodule

// File: tb/bus_lock_window_tb.sv
module bus_lock_window_tb;

  localparam int WINDOW = 32;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic lock_op = 1'b0, mem_wr_done = 1'b0, exc_raise = 1'b0;
  logic bus_lock, irq_mask, lock_timed_out;

  int vectors = 0;
  int miscompares = 0;

  // Reference state: value after the most recent edge.
  logic m_active = 1'b0;
  logic m_tmo = 1'b0;
  int   m_cnt = 0;

  always #5 clk = ~clk;

  bus_lock_window #(.WINDOW(WINDOW)) u_dut (
    .clk(clk), .rst(rst), .lock_op(lock_op), .mem_wr_done(mem_wr_done),
    .exc_raise(exc_raise), .bus_lock(bus_lock), .irq_mask(irq_mask),
    .lock_timed_out(lock_timed_out)
  );

  // Next-state rule taken from the requirements' priority order.
  task automatic model_step(input logic l, input logic w, input logic e);
    if (e) begin
      m_active = 1'b0; m_cnt = 0;
    end else if (l) begin
      m_active = 1'b1; m_cnt = WINDOW; m_tmo = 1'b0;
    end else if (m_active) begin
      if (w) begin
        m_active = 1'b0; m_cnt = 0;
      end else if (m_cnt == 1) begin
        m_active = 1'b0; m_cnt = 0; m_tmo = 1'b1;
      end else begin
        m_cnt = m_cnt - 1;
      end
    end
  endtask

  task automatic check_all(input string tag);
    vectors++;
    if (bus_lock !== m_active || irq_mask !== m_active || lock_timed_out !== m_tmo) begin
      miscompares++;
      $display("FAIL %s: got lock=%b mask=%b tmo=%b expected lock=%b mask=%b tmo=%b",
               tag, bus_lock, irq_mask, lock_timed_out, m_active, m_active, m_tmo);
    end
  endtask

  task automatic tick(input logic l, input logic w, input logic e, input string tag);
    lock_op = l; mem_wr_done = w; exc_raise = e;
    model_step(l, w, e);
    @(negedge clk);
    check_all(tag);
  endtask

  task automatic quiet(input int n, input string tag);
    for (int i = 0; i < n; i++) tick(1'b0, 1'b0, 1'b0, tag);
  endtask

  task automatic summary();
    $display("  == %0d vectors applied, %0d miscompares ==", vectors, miscompares);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    miscompares++;
    $display("FAIL watchdog: got running expected finished");
    summary();
    $finish;
  end

  initial begin
    void'($urandom(32'd20040920));
    repeat (3) @(negedge clk);
    check_all("R1 reset");
    rst = 1'b0;
    quiet(2, "R1 idle after reset");

    // R4: full countdown, sticky flag afterwards.
    tick(1'b1, 1'b0, 1'b0, "R2 entry");
    quiet(WINDOW - 1, "R4 held before expiry");
    tick(1'b0, 1'b0, 1'b0, "R4 expiry release");
    // R8 / R9: idle events leave flag and lock alone.
    tick(1'b0, 1'b1, 1'b0, "R9 write while idle");
    tick(1'b0, 1'b0, 1'b1, "R8 exception keeps flag");
    quiet(3, "R8 flag sticky");
    tick(1'b1, 1'b0, 1'b0, "R8 flag cleared on entry");

    // R7: restart mid-window.
    quiet(10, "R7 held");
    tick(1'b1, 1'b0, 1'b0, "R7 restart");
    quiet(WINDOW - 1, "R7 held after restart");
    tick(1'b0, 1'b0, 1'b0, "R7 expiry after restart");

    // R6: write release.
    tick(1'b1, 1'b0, 1'b0, "R2 entry");
    quiet(4, "R6 held");
    tick(1'b0, 1'b1, 1'b0, "R6 write release");

    // R5: exception with lock, locked and unlocked.
    tick(1'b1, 1'b0, 1'b0, "R2 entry");
    tick(1'b1, 1'b0, 1'b1, "R5 exception beats lock while held");
    tick(1'b1, 1'b0, 1'b1, "R5 exception beats lock while idle");

    // R10: lock with write, lock on last countdown cycle.
    tick(1'b1, 1'b0, 1'b0, "R2 entry");
    tick(1'b1, 1'b1, 1'b0, "R10 lock with write");
    quiet(WINDOW - 1, "R10 held to last cycle");
    tick(1'b1, 1'b0, 1'b0, "R10 lock on last cycle");
    quiet(WINDOW - 1, "R10 held after late restart");
    tick(1'b0, 1'b0, 1'b0, "R4 expiry");

    // Random traffic.
    for (int i = 0; i < 6000; i++) begin
      logic l, w, e;
      string tag;
      l = ($urandom % 24) == 0;
      w = ($urandom % 12) == 0;
      e = ($urandom % 40) == 0;
      if (($urandom % 4) == 0) w = 1'b0;
      if (e)             tag = "R5 random";
      else if (l)        tag = m_active ? "R7 random" : "R2 random";
      else if (!m_active) tag = w ? "R9 random" : "R8 random";
      else if (w)        tag = "R6 random";
      else               tag = "R4 random";
      tick(l, w, e, tag);
    end

    summary();
    $finish;
  end

endmodule